// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block sits between a memory controller's command stage and the SDRAM data path. For every column command it produces, one beat per clock, the column address that the burst touches. It also produces the per-beat write strobe and the cycle in which read data arrives at the pins. It reads the programmed mode word once per command. From the mode word it takes the number of beats, sequential or interleaved order, the read latency and the single-location write option. Bank and row management lie outside this block.

For reads it keeps a short pipeline that moves each beat by the read latency. It applies the byte-mask input with the two masking delays that SDRAM uses: same-cycle for writes and two cycles later for reads. Full-page bursts step through all columns, wrap and run until a terminate strobe arrives. A new command always replaces the burst in progress.

Top module: `sdr_burst_engine`

## Requirements
- R1: The burst length comes from mode bits [2:0]: 000 gives 1 beat, 001 gives 2, 010 gives 4 and 011 gives 8. The codes 100, 101 and 110 are reserved and give a single beat.
- R2: With mode bit 3 at 0 (sequential), beat k has the column ((start mod BL) + k) mod BL inside the BL-aligned block of the start column. The column bits above that block keep their value.
- R3: With mode bit 3 at 1 (interleaved), beat k has the column start XOR k.
- R4: Code 111 in bits [2:0] with mode bit 3 at 0 selects a full-page burst. The 9-bit column starts at the start column, adds one per beat, wraps from 511 to 0 and never ends by itself. Code 111 with mode bit 3 at 1 is reserved and gives a single beat.
- R5: `term` high at a clock edge (with no new command at that edge) stops the beats from that edge on. Read beats already issued still come out at their latency.
- R6: The read latency comes from mode bits [6:4]: code 010 gives latency 2 and code 011 gives latency 3. Any other code gives latency 3. Take the edge that captures a read command as edge 0. The data for beat k is then flagged on `rd_beat` in the cycle after edge k+latency, one cycle per beat.
- R7: During a write beat, `wr_en` is high only when `dqm` is low in that same cycle.
- R8: When `dqm` is high in cycle c, `rd_oe` is low in cycle c+2, including on a read data beat. At all other times `rd_oe` follows `rd_beat`.
- R9: With mode bit 9 at 1, a write runs for exactly one beat whatever the length code says. Reads keep their coded length.
- R10: A command that arrives during a burst cancels the remaining beats. The new burst starts at the next cycle from its own start column.
- R11: During reset and in the first cycle after it, `beat_valid`, `wr_en`, `rd_beat` and `rd_oe` are low.
- R12: Take the edge that captures a command as edge 0. Beat k appears on `beat_valid`/`beat_col` in the cycle after edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | A read or write column command in this cycle |
| cmd_write | input | 1 | 1 = write command, 0 = read command |
| cmd_col | input | COL_W | Start column of the command |
| mode_word | input | MODE_W | Programmed mode word (length, order, latency, write mode) |
| dqm | input | 1 | Data mask: write mask now, read output disable two cycles later |
| term | input | 1 | Burst terminate strobe |
| beat_valid | output | 1 | A burst beat is active in this cycle |
| beat_col | output | COL_W | Column address of the current beat |
| wr_en | output | 1 | Write the current beat (write burst and not masked) |
| rd_beat | output | 1 | Read data for a beat is on the bus in this cycle |
| rd_oe | output | 1 | Drive read data in this cycle (read beat and not masked) |

## Verification
A corrupted beat index or base column shows on `beat_col` in the very next beat. The bench compares every beat column, so the error is caught within one cycle of its cause. A wrong remaining-beat count or a missed terminate shows as an extra or missing beat in the first cycle after the burst should have ended. A latency or read mask that is off by one stage shows as `rd_beat` or `rd_oe` one cycle early or late. The scoreboard checks the exact cycle of every read beat, so such a shift is caught at the first read data beat.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;

    localparam int MODE_W      = 12;
    localparam int FLD_W       = 3;
    localparam int LEN_LSB     = 0;
    localparam int ORDER_BIT   = 3;
    localparam int LAT_LSB     = 4;
    localparam int WSINGLE_BIT = 9;
    localparam int LAT_W       = 2;
    localparam int RD_MASK_LAT = 2;

    localparam logic [FLD_W-1:0] LEN_1    = 3'b000;
    localparam logic [FLD_W-1:0] LEN_2    = 3'b001;
    localparam logic [FLD_W-1:0] LEN_4    = 3'b010;
    localparam logic [FLD_W-1:0] LEN_8    = 3'b011;
    localparam logic [FLD_W-1:0] LEN_PAGE = 3'b111;
    localparam logic [FLD_W-1:0] LAT_2    = 3'b010;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } order_e;

    typedef struct packed {
        logic             full_page;
        order_e           order;
        logic [LAT_W-1:0] lat;
        logic [FLD_W-1:0] len_mask;
    } burst_cfg_t;

    typedef struct packed {
        logic             valid;
        logic [LAT_W-1:0] lat;
    } rd_stage_t;

    function automatic burst_cfg_t decode_mode(input logic [MODE_W-1:0] mw,
                                               input logic             is_write);
        burst_cfg_t c;
        logic [FLD_W-1:0] len_code;
        len_code    = mw[LEN_LSB +: FLD_W];
        c.order     = order_e'(mw[ORDER_BIT]);
        c.lat       = (mw[LAT_LSB +: FLD_W] == LAT_2) ? 2'd2 : 2'd3;
        c.full_page = 1'b0;
        unique case (len_code)
            LEN_1:    c.len_mask = 3'd0;
            LEN_2:    c.len_mask = 3'd1;
            LEN_4:    c.len_mask = 3'd3;
            LEN_8:    c.len_mask = 3'd7;
            LEN_PAGE: begin
                c.len_mask  = 3'd0;
                c.full_page = (c.order == ORD_SEQ);
            end
            default:  c.len_mask = 3'd0;
        endcase
        if (is_write && mw[WSINGLE_BIT]) begin
            c.len_mask  = 3'd0;
            c.full_page = 1'b0;
        end
        return c;
    endfunction

endpackage

// File: rtl/sdr_mode_decode.sv
module sdr_mode_decode
    import sdr_burst_pkg::*;
(
    input  logic [MODE_W-1:0] mode_word,
    input  logic              is_write,
    output burst_cfg_t        cfg
);
    always_comb begin
        cfg = decode_mode(mode_word, is_write);
    end
endmodule

// File: rtl/sdr_beat_gen.sv
module sdr_beat_gen
    import sdr_burst_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             start_write,
    input  logic [COL_W-1:0] start_col,
    input  burst_cfg_t       cfg_in,
    input  logic             term,
    output logic             beat_valid,
    output logic             beat_write,
    output logic [COL_W-1:0] beat_col,
    output logic [LAT_W-1:0] beat_lat
);
    logic             active_q;
    logic             write_q;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] idx_q;
    logic [FLD_W-1:0] left_q;
    burst_cfg_t       cfg_q;

    logic [COL_W-1:0] wrap_mask;
    logic [COL_W-1:0] seq_col;
    logic [COL_W-1:0] ilv_col;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            write_q  <= 1'b0;
            base_q   <= '0;
            idx_q    <= '0;
            left_q   <= '0;
            cfg_q    <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            write_q  <= start_write;
            base_q   <= start_col;
            idx_q    <= '0;
            left_q   <= cfg_in.len_mask;
            cfg_q    <= cfg_in;
        end else if (term) begin
            active_q <= 1'b0;
        end else if (active_q) begin
            if (!cfg_q.full_page && left_q == '0) begin
                active_q <= 1'b0;
            end else begin
                idx_q  <= idx_q + 1'b1;
                left_q <= left_q - 1'b1;
            end
        end
    end

    always_comb begin
        wrap_mask = cfg_q.full_page ? '1 : COL_W'(cfg_q.len_mask);
        seq_col   = (base_q & ~wrap_mask) | ((base_q + idx_q) & wrap_mask);
        ilv_col   = base_q ^ (idx_q & wrap_mask);
    end

    assign beat_valid = active_q;
    assign beat_write = write_q;
    assign beat_col   = (cfg_q.order == ORD_ILV) ? ilv_col : seq_col;
    assign beat_lat   = cfg_q.lat;
endmodule

// File: rtl/sdr_read_pipe.sv
module sdr_read_pipe
    import sdr_burst_pkg::*;
#(
    parameter int MAX_LAT = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_in,
    input  logic [LAT_W-1:0] rd_lat,
    input  logic             dqm,
    output logic             rd_beat,
    output logic             rd_oe
);
    localparam int DEPTH = MAX_LAT;

    rd_stage_t              stage_q [DEPTH];
    logic [RD_MASK_LAT-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= '{valid: rd_in, lat: rd_lat};
    end

    generate
        for (genvar i = 1; i < DEPTH; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage_q[i] <= '0;
                else     stage_q[i] <= stage_q[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= {mask_q[RD_MASK_LAT-2:0], dqm};
    end

    always_comb begin
        rd_beat = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (stage_q[i].valid && int'(stage_q[i].lat) == i + 1) rd_beat = 1'b1;
        end
    end

    assign rd_oe = rd_beat & ~mask_q[RD_MASK_LAT-1];
endmodule

// File: rtl/sdr_burst_engine.sv
module sdr_burst_engine
    import sdr_burst_pkg::*;
#(
    parameter int COL_W   = 9,
    parameter int MAX_LAT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              dqm,
    input  logic              term,
    output logic              beat_valid,
    output logic [COL_W-1:0]  beat_col,
    output logic              wr_en,
    output logic              rd_beat,
    output logic              rd_oe
);
    burst_cfg_t       cfg;
    logic             beat_write;
    logic [LAT_W-1:0] beat_lat;

    sdr_mode_decode u_dec (
        .mode_word (mode_word),
        .is_write  (cmd_write),
        .cfg       (cfg)
    );

    sdr_beat_gen #(.COL_W(COL_W)) u_gen (
        .clk         (clk),
        .rst         (rst),
        .start       (cmd_valid),
        .start_write (cmd_write),
        .start_col   (cmd_col),
        .cfg_in      (cfg),
        .term        (term),
        .beat_valid  (beat_valid),
        .beat_write  (beat_write),
        .beat_col    (beat_col),
        .beat_lat    (beat_lat)
    );

    sdr_read_pipe #(.MAX_LAT(MAX_LAT)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_in   (beat_valid & ~beat_write),
        .rd_lat  (beat_lat),
        .dqm     (dqm),
        .rd_beat (rd_beat),
        .rd_oe   (rd_oe)
    );

    assign wr_en = beat_valid & beat_write & ~dqm;
endmodule

// File: rtl/sdr_burst_engine_chk.sv
module sdr_burst_engine_chk (
    input logic clk,
    input logic rst,
    input logic cmd_valid,
    input logic dqm,
    input logic term,
    input logic beat_valid,
    input logic wr_en,
    input logic rd_beat,
    input logic rd_oe
);
    a_r11_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!beat_valid && !wr_en && !rd_beat && !rd_oe));

    a_r12_beat_follows_cmd: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> beat_valid);

    a_r7_write_masked: assert property (@(posedge clk) disable iff (rst)
        dqm |-> !wr_en);

    a_r8_read_masked: assert property (@(posedge clk) disable iff (rst)
        rd_oe |-> !$past(dqm, 2));

    a_r8_oe_only_on_beat: assert property (@(posedge clk) disable iff (rst)
        rd_oe |-> rd_beat);

    a_r5_term_stops: assert property (@(posedge clk) disable iff (rst)
        (term && !cmd_valid) |=> !beat_valid);

    a_r7_wr_needs_beat: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> beat_valid);
endmodule

bind sdr_burst_engine sdr_burst_engine_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .dqm        (dqm),
    .term       (term),
    .beat_valid (beat_valid),
    .wr_en      (wr_en),
    .rd_beat    (rd_beat),
    .rd_oe      (rd_oe)
);

// File: tb/sdr_burst_engine_bench.sv
module sdr_burst_engine_bench;
    localparam int COL_W = 9;
    localparam int PAGE  = 512;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cmd_valid = 1'b0;
    logic             cmd_write = 1'b0;
    logic [COL_W-1:0] cmd_col = '0;
    logic [11:0]      mode_word = '0;
    logic             dqm = 1'b0;
    logic             term = 1'b0;
    logic             beat_valid;
    logic [COL_W-1:0] beat_col;
    logic             wr_en;
    logic             rd_beat;
    logic             rd_oe;

    sdr_burst_engine u_sdr_burst_engine (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_write  (cmd_write),
        .cmd_col    (cmd_col),
        .mode_word  (mode_word),
        .dqm        (dqm),
        .term       (term),
        .beat_valid (beat_valid),
        .beat_col   (beat_col),
        .wr_en      (wr_en),
        .rd_beat    (rd_beat),
        .rd_oe      (rd_oe)
    );

    always #5 clk = ~clk;

    typedef struct {
        int    cyc;
        int    col;
        bit    wr_en;
        string req;
    } beat_item_t;

    typedef struct {
        int    cyc;
        bit    oe;
        string req;
    } rd_item_t;

    beat_item_t beat_q[$];
    rd_item_t   rd_q[$];
    int checks   = 0;
    int failures = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // monitor: pop expected beats and read data as they appear
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (beat_valid) begin
                if (beat_q.size() == 0) begin
                    check(1'b0, "R12", "unexpected beat col", int'(beat_col), -1);
                end else begin
                    beat_item_t e;
                    e = beat_q.pop_front();
                    check(cyc == e.cyc, e.req, "beat cycle", cyc, e.cyc);
                    check(int'(beat_col) == e.col, e.req, "beat col", int'(beat_col), e.col);
                    check(wr_en == e.wr_en, e.req, "wr_en", int'(wr_en), int'(e.wr_en));
                end
            end else begin
                check(!wr_en, "R7", "wr_en without beat", int'(wr_en), 0);
            end
            if (rd_beat) begin
                if (rd_q.size() == 0) begin
                    check(1'b0, "R6", "unexpected read beat", 1, 0);
                end else begin
                    rd_item_t r;
                    r = rd_q.pop_front();
                    check(cyc == r.cyc, r.req, "read beat cycle", cyc, r.cyc);
                    check(rd_oe == r.oe, r.req, "rd_oe", int'(rd_oe), int'(r.oe));
                end
            end else begin
                check(!rd_oe, "R8", "rd_oe without read beat", int'(rd_oe), 0);
            end
        end
    end

    function automatic logic [11:0] mk_mode(bit wsingle, bit [2:0] lat_code,
                                            bit ilv, bit [2:0] len_code);
        return {2'b00, wsingle, 2'b00, lat_code, ilv, len_code};
    endfunction

    function automatic int model_col(int start, int k, int len, bit ilv, bit page);
        int off;
        if (page) return (start + k) % PAGE;
        if (ilv)  return start ^ k;
        off = start % len;
        return (start - off) + ((off + k) % len);
    endfunction

    // put command on the inputs; returns with cyc equal to the capture edge
    task automatic issue(input bit wr, input int col, input logic [11:0] mw, output int e0);
        cmd_valid = 1'b1;
        cmd_write = wr;
        cmd_col   = COL_W'(col);
        mode_word = mw;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        e0 = cyc;
    endtask

    task automatic run_burst(input bit wr, input int col, input logic [11:0] mw,
                             input int shown, input int len, input bit ilv,
                             input bit page, input int lat, input bit [15:0] dpat,
                             input bit stop, input string req);
        int e0;
        issue(wr, col, mw, e0);
        for (int i = 0; i < shown; i++) begin
            beat_item_t b;
            dqm  = dpat[i];
            term = stop && (i == shown - 1);
            b.cyc   = e0 + i;
            b.col   = model_col(col, i, len, ilv, page);
            b.wr_en = wr && !dpat[i];
            b.req   = req;
            beat_q.push_back(b);
            if (!wr) begin
                rd_item_t r;
                int j;
                j = i + lat - 2;
                r.cyc = e0 + i + lat;
                r.oe  = !((j < shown) ? dpat[j] : 1'b0);
                r.req = req;
                rd_q.push_back(r);
            end
            @(posedge clk); #1;
        end
        dqm  = 1'b0;
        term = 1'b0;
        repeat (6) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int e0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!beat_valid && !wr_en && !rd_beat && !rd_oe, "R11", "outputs in reset",
              int'({beat_valid, wr_en, rd_beat, rd_oe}), 0);
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        check(!beat_valid && !rd_beat && !rd_oe, "R11", "outputs after reset",
              int'({beat_valid, rd_beat, rd_oe}), 0);
        @(posedge clk); #1;

        // R2 R6 R12: sequential 4-beat read, latency 2, start 6 -> 6 7 4 5
        run_burst(0, 6, mk_mode(0, 3'b010, 0, 3'b010), 4, 4, 0, 0, 2, 16'h0, 0, "R2");
        // R3 R7: interleaved 8-beat write, start 5, beat 2 masked
        run_burst(1, 5, mk_mode(0, 3'b011, 1, 3'b011), 8, 8, 1, 0, 3, 16'h0004, 0, "R3");
        // R8 R6: sequential 8-beat read, latency 3, dqm in beat-3 cycle masks data of beat 2
        run_burst(0, 13, mk_mode(0, 3'b011, 0, 3'b011), 8, 8, 0, 0, 3, 16'h0008, 0, "R8");
        // R8: latency 2, dqm masks same-index data
        run_burst(0, 40, mk_mode(0, 3'b010, 0, 3'b010), 4, 4, 0, 0, 2, 16'h0002, 0, "R8");
        // R1: single beat and 2-beat sequential (101 -> 101,100)
        run_burst(0, 100, mk_mode(0, 3'b010, 0, 3'b000), 1, 1, 0, 0, 2, 16'h0, 0, "R1");
        run_burst(0, 101, mk_mode(0, 3'b010, 0, 3'b001), 2, 2, 0, 0, 2, 16'h0, 0, "R1");
        // R4 R5: full-page write from 509, wrap past 511, terminated after 6 beats
        run_burst(1, 509, mk_mode(0, 3'b010, 0, 3'b111), 6, 1, 0, 1, 2, 16'h0, 1, "R4");
        // R5: full-page read terminated; issued read data still arrives
        run_burst(0, 510, mk_mode(0, 3'b011, 0, 3'b111), 4, 1, 0, 1, 3, 16'h0, 1, "R5");
        // R9: single-location write ignores length 8; read keeps length 4
        run_burst(1, 77, mk_mode(1, 3'b010, 0, 3'b011), 1, 1, 0, 0, 2, 16'h0, 0, "R9");
        run_burst(0, 77, mk_mode(1, 3'b010, 0, 3'b010), 4, 4, 0, 0, 2, 16'h0, 0, "R9");
        // R1 R6: reserved length 100 -> one beat, reserved latency 000 -> 3
        run_burst(0, 200, mk_mode(0, 3'b000, 0, 3'b100), 1, 1, 0, 0, 3, 16'h0, 0, "R6");
        // R4: code 111 with interleave is reserved -> one beat
        run_burst(0, 300, mk_mode(0, 3'b010, 1, 3'b111), 1, 1, 1, 0, 2, 16'h0, 0, "R4");
        // R3: interleaved 4-beat read from 7 -> 7 6 5 4
        run_burst(0, 7, mk_mode(0, 3'b011, 1, 3'b010), 4, 4, 1, 0, 3, 16'h0, 0, "R3");

        // R10: 8-beat read from 16 cut after 3 beats by a write at 50
        issue(0, 16, mk_mode(0, 3'b010, 0, 3'b011), e0);
        for (int i = 0; i < 3; i++) begin
            beat_item_t b;
            rd_item_t   r;
            b.cyc = e0 + i; b.col = 16 + i; b.wr_en = 1'b0; b.req = "R10";
            beat_q.push_back(b);
            r.cyc = e0 + i + 2; r.oe = 1'b1; r.req = "R10";
            rd_q.push_back(r);
            if (i == 2) begin
                cmd_valid = 1'b1;
                cmd_write = 1'b1;
                cmd_col   = 9'd50;
                mode_word = mk_mode(0, 3'b010, 0, 3'b010);
            end
            @(posedge clk); #1;
        end
        cmd_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            beat_item_t b;
            b.cyc = e0 + 3 + i; b.col = model_col(50, i, 4, 0, 0); b.wr_en = 1'b1; b.req = "R10";
            beat_q.push_back(b);
        end
        repeat (10) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        check(beat_q.size() == 0, "R12", "beats never produced", beat_q.size(), 0);
        check(rd_q.size() == 0, "R6", "read beats never produced", rd_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule